// File: doc/BRIEF.md
# Condition Flag Register and Branch Outcome Resolver

This block holds the four processor condition flags (negative, zero, carry, overflow) and decides whether a control-transfer instruction is taken. The flag register loads the arithmetic unit's flag bus only on cycles where the set-flags strobe is high. Otherwise it keeps its contents, so a compare can be separated from the branch that consumes it by any number of instructions.

Each cycle the resolver receives a branch kind, a 4-bit condition code and a register-is-zero indication. It evaluates direct and register-indirect jumps, the two compare-with-zero forms and fourteen flag conditions. A conditional branch is judged against the flags already held in the register. The verdict is registered, so `taken` reflects the instruction presented one clock earlier. This matches a pipeline that resolves branches one stage after the flags are read.

The flag register moves between two conditions, holding and loading, and the strobe selects between them. The outcome register moves between not-taken and taken. After reset it is not-taken, and each edge moves it to the verdict for the current inputs. Target address generation and link-register writes are handled elsewhere.

Top module: `branch_resolver`

## Requirements
- R1: A synchronous reset clears all four flags and drives `taken` low at the following edge, whatever the branch inputs are.
- R2: At an edge where `set_flags` is 1, the flags take the value of `alu_flags`, with bit 3 = N, bit 2 = Z, bit 1 = C and bit 0 = V. At an edge where `set_flags` is 0, the flags are unchanged, whatever `alu_flags` carries.
- R3: `br_kind` 3'd0 (no branch) never sets `taken`. 3'd1 (direct or direct-with-link) and 3'd2 (register-indirect) always set it.
- R4: `br_kind` 3'd3 (branch if zero) is taken exactly when `rs_zero` is 1. `br_kind` 3'd4 (branch if nonzero) is taken exactly when `rs_zero` is 0.
- R5: `br_kind` 3'd5 (flag condition) uses `br_cond` with this encoding: 0 equal (Z), 1 not equal (!Z), 2 unsigned higher-or-same (C), 3 unsigned lower (!C), 4 minus (N), 5 plus (!N), 6 overflow (V), 7 no overflow (!V).
- R6: Further `br_cond` codes: 8 unsigned higher (C & !Z), 9 unsigned lower-or-same (!C | Z), 10 signed greater-or-equal (N==V), 11 signed less (N!=V), 12 signed greater (!Z & N==V), 13 signed less-or-equal (Z | N!=V).
- R7: `br_cond` codes 14 and 15, and `br_kind` codes 6 and 7, never set `taken`.
- R8: `taken` is registered and shows the verdict for the inputs sampled at the previous edge. A flag condition is judged against the flags held before that edge, so a flag write in the same cycle affects only later branches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| alu_flags | input | 4 | Flag bus from the arithmetic unit {N,Z,C,V} |
| set_flags | input | 1 | Load strobe for the flag register |
| br_kind | input | 3 | Branch kind code |
| br_cond | input | 4 | Condition code for flag branches |
| rs_zero | input | 1 | Tested register equals zero |
| taken | output | 1 | Registered branch verdict |

## Verification
A flag load and a flag-conditional branch can arrive in the same cycle. In that case the branch must see the old flags and the new ones must reach only the next branch. The bench provokes this by loading Z=1, then presenting an equal-condition branch together with a load of all-zero flags, and then repeating the branch without a load. The reference model computes the verdict before applying the flag write, so it expects taken and then not-taken. The same collision is exercised with a compare-with-zero branch, whose verdict must not depend on the flags at all.

// File: rtl/brres_pkg.sv
package brres_pkg;
    localparam int FLAG_W = 4;
    localparam int COND_W = 4;
    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        K_NONE   = 3'd0,
        K_DIRECT = 3'd1,
        K_REGIND = 3'd2,
        K_IFZERO = 3'd3,
        K_IFNZ   = 3'd4,
        K_FLAGC  = 3'd5,
        K_RSV6   = 3'd6,
        K_RSV7   = 3'd7
    } kind_e;

    typedef enum logic [COND_W-1:0] {
        C_EQ = 4'd0,  C_NE = 4'd1,  C_HS = 4'd2,  C_LO = 4'd3,
        C_MI = 4'd4,  C_PL = 4'd5,  C_VS = 4'd6,  C_VC = 4'd7,
        C_HI = 4'd8,  C_LS = 4'd9,  C_GE = 4'd10, C_LT = 4'd11,
        C_GT = 4'd12, C_LE = 4'd13, C_X14 = 4'd14, C_X15 = 4'd15
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;
endpackage

// File: rtl/flag_store.sv
module flag_store
    import brres_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  nzcv_t d,
    output nzcv_t q
);
    nzcv_t q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
        end else if (load) begin
            q_r <= d;
        end
    end

    assign q = q_r;

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !load |=> q == $past(q))
        else $error("flags changed without load");

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> q == $past(d))
        else $error("flags did not load bus");

    p_clear_r1: assert property (@(posedge clk)
        rst |=> q == '0)
        else $error("flags not cleared by reset");
endmodule

// File: rtl/cond_eval.sv
module cond_eval
    import brres_pkg::*;
(
    input  logic [COND_W-1:0] cc,
    input  nzcv_t             f,
    output logic              hit
);
    logic sign_ok;

    assign sign_ok = (f.n == f.v);

    always_comb begin
        unique case (cond_e'(cc))
            C_EQ:    hit = f.z;
            C_NE:    hit = !f.z;
            C_HS:    hit = f.c;
            C_LO:    hit = !f.c;
            C_MI:    hit = f.n;
            C_PL:    hit = !f.n;
            C_VS:    hit = f.v;
            C_VC:    hit = !f.v;
            C_HI:    hit = f.c && !f.z;
            C_LS:    hit = !f.c || f.z;
            C_GE:    hit = sign_ok;
            C_LT:    hit = !sign_ok;
            C_GT:    hit = !f.z && sign_ok;
            C_LE:    hit = f.z || !sign_ok;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
    import brres_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [FLAG_W-1:0] alu_flags,
    input  logic              set_flags,
    input  logic [KIND_W-1:0] br_kind,
    input  logic [COND_W-1:0] br_cond,
    input  logic              rs_zero,
    output logic              taken
);
    nzcv_t flags_q;
    logic  cond_hit;
    logic  verdict;
    logic  taken_q;

    flag_store u_flags (
        .clk  (clk),
        .rst  (rst),
        .load (set_flags),
        .d    (nzcv_t'(alu_flags)),
        .q    (flags_q)
    );

    cond_eval u_cond (
        .cc  (br_cond),
        .f   (flags_q),
        .hit (cond_hit)
    );

    always_comb begin
        unique case (kind_e'(br_kind))
            K_DIRECT,
            K_REGIND: verdict = 1'b1;
            K_IFZERO: verdict = rs_zero;
            K_IFNZ:   verdict = !rs_zero;
            K_FLAGC:  verdict = cond_hit;
            default:  verdict = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            taken_q <= 1'b0;
        end else begin
            taken_q <= verdict;
        end
    end

    assign taken = taken_q;

    p_reset_low_r1: assert property (@(posedge clk)
        rst |=> !taken)
        else $error("taken high after reset");

    p_none_r3: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 3'd0) |=> !taken)
        else $error("no-branch produced taken");

    p_jump_r3: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 3'd1 || br_kind == 3'd2) |=> taken)
        else $error("unconditional not taken");

    p_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 3'd3) |=> taken == $past(rs_zero))
        else $error("branch-if-zero wrong");

    p_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 3'd4) |=> taken == !$past(rs_zero))
        else $error("branch-if-nonzero wrong");

    p_rsv_kind_r7: assert property (@(posedge clk) disable iff (rst)
        (br_kind[2:1] == 2'b11) |=> !taken)
        else $error("reserved kind taken");

    p_rsv_cond_r7: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 3'd5 && br_cond[3:1] == 3'b111) |=> !taken)
        else $error("reserved condition taken");
endmodule

// File: tb/branch_resolver_bench.sv
`timescale 1ns/1ps
module branch_resolver_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] alu_flags = '0;
    logic       set_flags = 1'b0;
    logic [2:0] br_kind = '0;
    logic [3:0] br_cond = '0;
    logic       rs_zero = 1'b0;
    logic       taken;

    int         checks = 0;
    int         errors = 0;
    logic [3:0] model_flags = '0;
    logic       exp_taken = 1'b0;
    bit         pend = 1'b0;
    string      pend_tag = "";

    always #4 clk = ~clk;

    branch_resolver u_branch_resolver (
        .clk       (clk),
        .rst       (rst),
        .alu_flags (alu_flags),
        .set_flags (set_flags),
        .br_kind   (br_kind),
        .br_cond   (br_cond),
        .rs_zero   (rs_zero),
        .taken     (taken)
    );

    function automatic logic model_cond(input logic [3:0] fl, input int code);
        logic n, z, c, v;
        n = fl[3]; z = fl[2]; c = fl[1]; v = fl[0];
        if (code == 0)  return z;
        if (code == 1)  return !z;
        if (code == 2)  return c;
        if (code == 3)  return !c;
        if (code == 4)  return n;
        if (code == 5)  return !n;
        if (code == 6)  return v;
        if (code == 7)  return !v;
        if (code == 8)  return c & !z;
        if (code == 9)  return !c | z;
        if (code == 10) return n == v;
        if (code == 11) return n != v;
        if (code == 12) return !z & (n == v);
        if (code == 13) return z | (n != v);
        return 1'b0;
    endfunction

    function automatic logic model_verdict(input int k, input int c,
                                           input logic z, input logic [3:0] fl);
        if (k == 1 || k == 2) return 1'b1;
        if (k == 3) return z;
        if (k == 4) return !z;
        if (k == 5) return model_cond(fl, c);
        return 1'b0;
    endfunction

    task automatic check_prev();
        if (pend) begin
            checks++;
            if (taken !== exp_taken) begin
                errors++;
                $display("FAIL %s: taken=%b expected=%b", pend_tag, taken, exp_taken);
            end
        end
    endtask

    task automatic step(input int k, input int c, input logic z,
                        input logic s, input logic [3:0] f, input string tag);
        @(negedge clk);
        check_prev();
        br_kind   = 3'(k);
        br_cond   = 4'(c);
        rs_zero   = z;
        set_flags = s;
        alu_flags = f;
        exp_taken = model_verdict(k, c, z, model_flags);
        pend      = 1'b1;
        pend_tag  = tag;
        if (s) model_flags = f;
    endtask

    task automatic do_reset();
        @(negedge clk);
        check_prev();
        rst       = 1'b1;
        br_kind   = 3'd1;
        set_flags = 1'b1;
        alu_flags = 4'hF;
        exp_taken = 1'b0;
        pend      = 1'b1;
        pend_tag  = "R1 reset";
        model_flags = '0;
        @(negedge clk);
        check_prev();
        rst       = 1'b0;
        br_kind   = 3'd0;
        set_flags = 1'b0;
        alu_flags = '0;
        pend      = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: taken=%b expected=finish", taken);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1: flags cleared by reset -> EQ not taken, NE taken
        step(5, 0, 1'b0, 1'b0, 4'h0, "R1 EQ after reset");
        step(5, 1, 1'b0, 1'b0, 4'h0, "R1 NE after reset");

        // R3 / R4 / R7 kind coverage
        step(0, 0, 1'b1, 1'b0, 4'h0, "R3 none");
        step(1, 0, 1'b0, 1'b0, 4'h0, "R3 direct");
        step(2, 0, 1'b0, 1'b0, 4'h0, "R3 indirect");
        step(3, 0, 1'b1, 1'b0, 4'h0, "R4 ifzero z=1");
        step(3, 0, 1'b0, 1'b0, 4'h0, "R4 ifzero z=0");
        step(4, 0, 1'b1, 1'b0, 4'h0, "R4 ifnz z=1");
        step(4, 0, 1'b0, 1'b0, 4'h0, "R4 ifnz z=0");
        step(6, 0, 1'b1, 1'b0, 4'h0, "R7 kind6");
        step(7, 0, 1'b1, 1'b0, 4'h0, "R7 kind7");

        // R5 / R6 / R7: every condition against all 16 flag sets
        for (int f = 0; f < 16; f++) begin
            step(0, 0, 1'b0, 1'b1, 4'(f), "R2 load");
            for (int c = 0; c < 16; c++) begin
                string t;
                if (c < 8)       t = $sformatf("R5 cond=%0d flags=%0h", c, f);
                else if (c < 14) t = $sformatf("R6 cond=%0d flags=%0h", c, f);
                else             t = $sformatf("R7 cond=%0d flags=%0h", c, f);
                step(5, c, 1'b0, 1'b0, 4'(15 - f), t);
            end
        end

        // R2 hold: bus changes without strobe
        step(0, 0, 1'b0, 1'b1, 4'b0100, "R2 load Z");
        step(5, 0, 1'b0, 1'b0, 4'b0000, "R2 hold EQ");
        step(5, 0, 1'b0, 1'b0, 4'b1011, "R2 hold EQ again");

        // R8 collision: load and conditional branch in same cycle
        step(5, 0, 1'b0, 1'b1, 4'b0000, "R8 EQ sees old flags");
        step(5, 0, 1'b0, 1'b0, 4'b0000, "R8 EQ sees new flags");
        step(3, 0, 1'b1, 1'b1, 4'b0100, "R8 ifzero with load");
        step(5, 1, 1'b0, 1'b0, 4'b0000, "R8 NE after load Z");
        step(5, 12, 1'b0, 1'b1, 4'b1001, "R8 GT old flags");
        step(5, 12, 1'b0, 1'b0, 4'b0000, "R8 GT new flags");

        // R1 mid-run reset clears flags
        step(0, 0, 1'b0, 1'b1, 4'b0100, "R2 load Z");
        do_reset();
        step(5, 0, 1'b0, 1'b0, 4'h0, "R1 EQ cleared");
        step(0, 0, 1'b0, 1'b0, 4'h0, "R3 tail");

        @(negedge clk);
        check_prev();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule